// File: doc/BRIEF.md
# Register-Loaded Frame Stream Transmitter

This block holds one frame of up to `DEPTH` 32-bit words in a small buffer that software fills through a simple register port. When software sets the start bit, the block sends the first N words of the buffer, in index order, as one packet on an AXI4-Stream master port. N is the programmed frame length. The final word carries TLAST, and the sender obeys TREADY backpressure.

When a run ends, the block publishes a status word. It carries error flags, the number of words sent, a running frame sequence number and the buffer capacity. A companion valid flag marks a fresh status word and clears when software reads it. A length of zero sends nothing and serves as a capacity query. A length above the buffer depth is rejected, flagged and sends nothing.

The control side offers start, done, idle and ready bits and an auto-restart bit. It also has a global interrupt enable, per-source interrupt enables and an interrupt status register whose bits toggle when software writes a 1 to them.

Top module: `frame_tx_regs`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x0000000C, which is idle and ready set with start, done and auto-restart clear. The status valid register (0x84) reads 0 and `irq` is low.
- R2: A read presents its data on `rd_data` on the cycle after `rd_en`. The frame length register at 0x10 and buffer word n at 0x40+4n read back what was last written to them.
- R3: Writing 1 to control bit 0 while the block is idle starts one run. Start, idle (bit 2) and ready (bit 3) all read 0 while the run is in flight, unless auto-restart is set, in which case start stays set.
- R4: For a length N in 1..DEPTH, the stream carries buffer words 0..N-1 in order, one per handshake, with TLAST high only on word N-1.
- R5: While TVALID is high and TREADY is low, TDATA and TLAST hold steady. Under any TREADY pattern, no word is dropped or repeated.
- R6: A run with length 0 sends no words. It completes with status count 0, all flags 0 and bits 31:26 equal to DEPTH (16).
- R7: A run with length above DEPTH sends no words. It completes with status bit 2 (too long) and bit 3 (invalid size) set and count 0.
- R8: The status word at 0x80 has this layout: bit 0 is running, which reads the live busy state; bit 1 is too-short, which is always 0 because the buffer cannot underrun; bits 9:4 hold the words sent; bits 25:10 hold the sequence number; bits 31:26 hold DEPTH.
- R9: The sequence number equals the count of completed non-empty frames, modulo 2^16. Zero-length and rejected runs leave it unchanged.
- R10: At the end of each run, done (control bit 1) and the status valid bit (0x84 bit 0) both set. Done clears when the control register is read, and the valid bit clears when 0x84 is read.
- R11: 0x04 bit 0 is the global interrupt enable. 0x08 holds per-source enables: bit 0 for run end and bit 1 for start accepted. 0x0C holds the status bits in the same positions; an enabled event sets its bit, and writing 1 to a bit toggles it. `irq` is the global enable ANDed with the OR of the status bits.
- R12: With auto-restart (control bit 7) set, a new run starts right after each finished run. The runs stop once a control write clears bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| m_tdata | output | 32 | Stream data word |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Last word of the frame |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every length from 0 to 17, plus 31 and the all-ones value, under four TREADY patterns. The patterns are always ready, alternating, mostly ready and sparse. A wrong off-by-one in the length check would send a 17th word or reject a length of 16. A broken stall path would drop or repeat words, and the bench catches this against a computed pattern. A misplaced TLAST would end the packet early.

Each run also checks the status word field by field against the expected sequence count. A design that counted empty runs or rejected lengths would drift on the sequence number. The clear-on-read flags are read twice, so a flag that never clears is exposed. The toggle-on-write interrupt status is written while set and again while clear. An auto-restart that never stops would hang the idle poll.

// File: rtl/frame_tx_regs.sv
module frame_tx_regs #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int SEQW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic [DW-1:0] m_tdata,
  output logic          m_tvalid,
  input  logic          m_tready,
  output logic          m_tlast,
  output logic          irq
);
  localparam int IW  = $clog2(DEPTH);
  localparam int CW  = 6;
  localparam int MW  = 32 - CW - SEQW - 4 - CW;
  localparam logic [AW-1:0] A_CTRL = 'h00, A_GIE = 'h04, A_IER = 'h08, A_ISR = 'h0C,
                            A_LEN = 'h10, A_STAT = 'h80, A_VLD = 'h84;
  localparam int BUF_TAG = 'h40 >> (IW + 2);

  logic            start_q, done_q, auto_q, gie_q, vld_q, sending;
  logic [1:0]      ier_q, isr_q;
  logic [31:0]     len_q, stat_q;
  logic [IW-1:0]   idx;
  logic [IW:0]     size_q;
  logic [SEQW-1:0] seq_q;
  logic [DW-1:0]   mem [DEPTH];

  wire wr_ctrl   = wr_en && wr_addr == A_CTRL;
  wire rd_ctrl   = rd_en && rd_addr == A_CTRL;
  wire rd_vld    = rd_en && rd_addr == A_VLD;
  wire wr_buf    = wr_en && wr_addr[AW-1:IW+2] == BUF_TAG[AW-IW-3:0];
  wire rd_buf    = rd_addr[AW-1:IW+2] == BUF_TAG[AW-IW-3:0];
  wire accept    = start_q && !sending;
  wire len_ok    = len_q != 0 && len_q <= DEPTH;
  wire len_big   = len_q > DEPTH;
  wire hs        = m_tvalid && m_tready;
  wire fin_frame = hs && m_tlast;
  wire fin_empty = accept && !len_ok;
  wire finish    = fin_frame || fin_empty;
  wire [SEQW-1:0] seq_nx = seq_q + 1'b1;
  wire [CW-1:0]   cap    = CW'(DEPTH);

  assign m_tvalid = sending;
  assign m_tdata  = mem[idx];
  assign m_tlast  = sending && ({1'b0, idx} == size_q - 1'b1);
  assign irq      = gie_q && (|isr_q);

  always_ff @(posedge clk)
    if (wr_buf) mem[wr_addr[IW+1:2]] <= wr_data[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0; done_q <= 1'b0; auto_q <= 1'b0; gie_q <= 1'b0;
      vld_q <= 1'b0; sending <= 1'b0; ier_q <= '0; isr_q <= '0;
      len_q <= '0; stat_q <= '0; idx <= '0; size_q <= '0; seq_q <= '0;
    end else begin
      if (accept)                   start_q <= auto_q;
      else if (wr_ctrl && wr_data[0]) start_q <= 1'b1;
      if (wr_ctrl)                  auto_q <= wr_data[7];
      if (wr_en && wr_addr == A_GIE) gie_q <= wr_data[0];
      if (wr_en && wr_addr == A_IER) ier_q <= wr_data[1:0];
      if (wr_en && wr_addr == A_LEN) len_q <= wr_data;

      isr_q <= (isr_q ^ ((wr_en && wr_addr == A_ISR) ? wr_data[1:0] : 2'b00))
             | {accept && ier_q[1], finish && ier_q[0]};

      if (finish)       done_q <= 1'b1;
      else if (rd_ctrl) done_q <= 1'b0;
      if (finish)       vld_q <= 1'b1;
      else if (rd_vld)  vld_q <= 1'b0;

      if (accept && len_ok) begin
        sending <= 1'b1;
        idx     <= '0;
        size_q  <= len_q[IW:0];
      end else if (hs) begin
        if (m_tlast) sending <= 1'b0;
        else         idx <= idx + 1'b1;
      end

      if (fin_frame) begin
        seq_q  <= seq_nx;
        stat_q <= {cap, {MW{1'b0}}, seq_nx, {(CW-IW-1){1'b0}}, size_q, 4'b0000};
      end else if (fin_empty) begin
        stat_q <= {cap, {MW{1'b0}}, seq_q, {CW{1'b0}}, len_big, len_big, 2'b00};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      if (rd_buf) rd_data <= 32'(mem[rd_addr[IW+1:2]]);
      else case (rd_addr)
        A_CTRL:  rd_data <= {24'd0, auto_q, 3'd0, !sending && !start_q, !sending, done_q, start_q};
        A_GIE:   rd_data <= {31'd0, gie_q};
        A_IER:   rd_data <= {30'd0, ier_q};
        A_ISR:   rd_data <= {30'd0, isr_q};
        A_LEN:   rd_data <= len_q;
        A_STAT:  rd_data <= stat_q | {31'd0, sending};
        A_VLD:   rd_data <= {31'd0, vld_q};
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

module frame_tx_chk #(
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int SEQW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DW-1:0]   m_tdata,
  input logic            m_tvalid,
  input logic            m_tready,
  input logic            m_tlast,
  input logic            irq,
  input logic            gie_q,
  input logic            done_q,
  input logic            vld_q,
  input logic [SEQW-1:0] seq_q,
  input logic [IW-1:0]   idx,
  input logic [IW:0]     size_q
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid);
  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> {1'b0, idx} < size_q);
  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> seq_q == SEQW'($past(seq_q) + 1'b1));
  // R10
  end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> done_q && vld_q);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie_q);
endmodule

bind frame_tx_regs frame_tx_chk #(.DW(DW), .IW(IW), .SEQW(SEQW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
  .m_tready(m_tready), .m_tlast(m_tlast), .irq(irq), .gie_q(gie_q),
  .done_q(done_q), .vld_q(vld_q), .seq_q(seq_q), .idx(idx), .size_q(size_q));

// File: tb/sim_frame_tx_regs.sv
module sim_frame_tx_regs;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, m_tready = 1;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data, m_tdata;
  logic m_tvalid, m_tlast, irq;

  frame_tx_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .irq(irq));

  always #10 clk = ~clk;

  int vectors = 0, errors = 0, nget = 0, rmode = 0, cyc = 0;
  logic [31:0] got [64];
  logic        glast [64];
  logic [15:0] seq_exp = 0;

  always @(negedge clk) begin
    cyc++;
    case (rmode)
      0: m_tready <= 1'b1;
      1: m_tready <= cyc[0];
      2: m_tready <= (cyc % 3) != 0;
      3: m_tready <= (cyc % 5) < 2;
      default: m_tready <= 1'b0;
    endcase
  end

  always begin
    @(negedge clk); #5;
    if (m_tvalid && m_tready && nget < 64) begin
      got[nget] = m_tdata; glast[nget] = m_tlast; nget++;
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  function automatic logic [31:0] pat(input int n, input int k);
    return 32'(32'h9E3779B9 * 32'(n * 17 + k + 1));
  endfunction

  task automatic wait_done();
    logic [31:0] v; int g = 0;
    do begin rd(8'h00, v); g++; end while (!v[1] && g < 2000);
  endtask

  task automatic run_frame(input logic [31:0] n, input int mode);
    logic [31:0] v, st; int ex;
    rmode = mode;
    for (int k = 0; k < 16; k++) wr(8'h40 + 8'(4 * k), pat(int'(n[7:0]), k));
    wr(8'h10, n);
    nget = 0;
    wr(8'h00, 32'h1);
    wait_done();
    repeat (3) @(negedge clk);
    ex = (n >= 1 && n <= 16) ? int'(n) : 0;
    chk($sformatf("R4 R6 R7 word count n=%0d", n), nget, ex);
    for (int k = 0; k < ex; k++) begin
      chk($sformatf("R4 R5 data n=%0d k=%0d", n, k), got[k], pat(int'(n[7:0]), k));
      chk($sformatf("R4 tlast n=%0d k=%0d", n, k), 32'(glast[k]), 32'(k == ex - 1));
    end
    if (ex > 0) seq_exp++;
    if (n > 16)      st = {6'd16, seq_exp, 6'd0, 4'b1100};
    else             st = {6'd16, seq_exp, 6'(ex), 4'b0000};
    rd(8'h84, v); chk($sformatf("R10 status valid n=%0d", n), v, 32'h1);
    rd(8'h84, v); chk("R10 status valid clears on read", v, 32'h0);
    rd(8'h80, v); chk($sformatf("R6 R7 R8 R9 status n=%0d", n), v, st);
    rd(8'h00, v); chk("R10 done cleared, idle", v, 32'h0000000C);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h00, v); chk("R1 ctrl after reset", v, 32'h0000000C);
    rd(8'h84, v); chk("R1 status valid after reset", v, 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);

    wr(8'h10, 32'h1234_5678); rd(8'h10, v); chk("R2 length readback", v, 32'h1234_5678);
    for (int k = 0; k < 16; k++) wr(8'h40 + 8'(4 * k), 32'hC0DE_0000 + 32'(k * 3));
    for (int k = 0; k < 16; k++) begin
      rd(8'h40 + 8'(4 * k), v); chk($sformatf("R2 buffer readback %0d", k), v, 32'hC0DE_0000 + 32'(k * 3));
    end

    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n <= 17; n++) run_frame(32'(n), m);
      run_frame(32'd31, m);
      run_frame(32'hFFFF_FFFF, m);
    end

    // R3: start bit clears on acceptance, running visible in status bit 0
    rmode = 4;
    wr(8'h10, 32'd4); nget = 0; wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R3 start cleared while busy", v, 32'h0);
    rd(8'h80, v); chk("R8 running bit live", 32'(v[0]), 32'h1);
    rmode = 0;
    wait_done();
    repeat (3) @(negedge clk);
    seq_exp++;
    chk("R5 held frame count", nget, 4);
    rd(8'h84, v);

    // R11: interrupt enables, status and toggle
    wr(8'h04, 32'h1); wr(8'h08, 32'h3);
    run_frame(32'd3, 0);
    rd(8'h0C, v); chk("R11 isr both sources", v, 32'h3);
    chk("R11 irq high", 32'(irq), 32'h1);
    wr(8'h0C, 32'h3); rd(8'h0C, v); chk("R11 isr toggled clear", v, 32'h0);
    chk("R11 irq low", 32'(irq), 32'h0);
    wr(8'h0C, 32'h1); rd(8'h0C, v); chk("R11 isr toggled set", v, 32'h1);
    wr(8'h04, 32'h0); @(negedge clk); chk("R11 irq gated off", 32'(irq), 32'h0);
    wr(8'h0C, 32'h1); wr(8'h08, 32'h0);

    // R12: auto-restart
    rmode = 0;
    for (int k = 0; k < 2; k++) wr(8'h40 + 8'(4 * k), pat(2, k));
    wr(8'h10, 32'd2); nget = 0;
    wr(8'h00, 32'h81);
    begin int g = 0; while (nget < 6 && g < 500) begin @(negedge clk); g++; end end
    wr(8'h00, 32'h0);
    begin int g = 0; do begin rd(8'h00, v); g++; end while ((!v[2] || v[0]) && g < 500); end
    repeat (3) @(negedge clk);
    vectors++;
    if (nget < 6 || nget % 2 != 0) begin
      errors++; $display("FAIL R12 auto-restart word count act=%0d exp=even>=6", nget);
    end
    for (int k = 0; k < nget; k++) begin
      chk($sformatf("R12 auto data %0d", k), got[k], pat(2, k % 2));
      chk($sformatf("R12 auto tlast %0d", k), 32'(glast[k]), 32'(k % 2));
    end
    seq_exp = seq_exp + 16'(nget / 2);
    rd(8'h80, v); chk("R9 R12 status after auto runs", v, {6'd16, seq_exp, 6'd2, 4'b0000});
    rd(8'h84, v);
    rd(8'h00, v); chk("R12 stopped and idle", v, 32'h0000000C);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule